// File: doc/BRIEF.md
# Bucketed receive message FIFO

This block is the receive side of one station on an on-chip message ring. Every message on the ring is addressed to a bucket, not to the station as a whole. The station holds a single shared storage array of `DEPTH` entries, 256 by default. Software carves this array into up to `NBKT` buckets, 8 by default, and each bucket behaves as its own circular queue inside its slice of the array. Bucket `i` begins at the sum of the sizes of buckets `0..i-1`. Every size is a power of two or zero, and each bucket's start must be a multiple of its own size. A bucket of size zero is unused, and every bucket is unused after reset.

Each incoming message carries a destination bucket, a sender ID and a payload. The block stores the sender ID together with the payload. A local consumer pops from any bucket it chooses. Each successful pop returns the oldest payload of that bucket and, in the same cycle, sends a one-cycle credit return to the original sender, carrying the sender ID and the bucket index.

Senders are expected to hold no more credits than the bucket size. A write that finds its bucket full therefore points to a wrong credit setup, and the block reports it as an error pulse. A write to an unused bucket is reported in the same way. A size write that breaks the layout rules sets a sticky configuration error.

Top module: `rfq_rx_station`

## Requirements
- R1: After reset every bucket size is 0, every `bkt_empty` bit is 1, and `deq_vld`, `cr_vld`, `err_unused`, `err_ovf` and `cfg_err` are all 0.
- R2: Bucket `i` occupies the entries from the sum of the sizes of buckets below `i`, for `size[i]` entries. Traffic in one bucket never changes the contents or the order of another bucket.
- R3: A size write (`cfg_we`) is accepted only if all of the following hold once the new value is put in place: every size is 0 or a power of two no larger than `DEPTH`, every nonzero bucket starts at a multiple of its size, and the sizes add up to at most `DEPTH`. Otherwise `cfg_err` becomes 1 on the next cycle, stays 1 until reset, and the stored sizes do not change.
- R4: An enqueue to a bucket of size 0 is discarded, and `err_unused` pulses high for one cycle on the next cycle.
- R5: An enqueue to a bucket holding `size` entries is discarded, `err_ovf` pulses high for one cycle on the next cycle, and the bucket's contents stay the same.
- R6: A pop of a nonempty bucket raises `deq_vld` on the next cycle, with that bucket's oldest payload on `deq_data` and its sender on `deq_sid`. A pop of an empty bucket produces no `deq_vld` and no credit.
- R7: Every successful pop raises `cr_vld` for one cycle, in the same cycle as `deq_vld`, with `cr_sid` equal to the stored sender and `cr_bkt` equal to the popped bucket.
- R8: A bucket's read and write positions wrap within its own slice, so first-in first-out order holds across any number of passes.
- R9: An enqueue and a pop in the same cycle on one nonempty bucket leave its occupancy unchanged. On an empty bucket the pop is ignored and the enqueue is stored.
- R10: `bkt_empty[i]` is 1 exactly when bucket `i` holds no entry, and it updates on the cycle after the enqueue or pop that changes the occupancy.
- R11: An accepted size write empties the bucket it targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Size write strobe |
| cfg_bkt | input | $clog2(NBKT) | Bucket targeted by the size write |
| cfg_size | input | $clog2(DEPTH)+1 | New bucket size in entries |
| cfg_err | output | 1 | Sticky flag for a rejected size write |
| enq_vld | input | 1 | Incoming message valid |
| enq_bkt | input | $clog2(NBKT) | Destination bucket |
| enq_sid | input | SID_W | Sender ID |
| enq_data | input | DATA_W | Payload |
| deq_req | input | 1 | Pop request from the local consumer |
| deq_bkt | input | $clog2(NBKT) | Bucket to pop |
| deq_vld | output | 1 | Popped message valid |
| deq_data | output | DATA_W | Popped payload |
| deq_sid | output | SID_W | Sender of the popped message |
| cr_vld | output | 1 | Credit-return pulse |
| cr_bkt | output | $clog2(NBKT) | Bucket the credit belongs to |
| cr_sid | output | SID_W | Sender that receives the credit |
| err_unused | output | 1 | Pulse: enqueue to an unused bucket was dropped |
| err_ovf | output | 1 | Pulse: enqueue to a full bucket was dropped |
| bkt_empty | output | NBKT | Per-bucket empty flags |

## Verification
Every result of this block is registered once. The pop data, the credit return, the two error pulses, the configuration error and the empty flags all appear one clock after the rising edge that takes the stimulus. The bench drives each stimulus on a falling edge, releases it on the next falling edge, and checks the outputs at that same falling edge, half a period after the edge that registered the result. Pulses are checked in their single valid cycle and again at quiet samples, so a pulse that lasts too long or fires on the wrong operation is also caught.

// File: rtl/rfq_pkg.sv
`timescale 1ns/1ps
package rfq_pkg;
    localparam int unsigned RFQ_DEPTH_DEF = 256;
    localparam int unsigned RFQ_NBKT_DEF  = 8;
    localparam int unsigned RFQ_DATA_DEF  = 16;
    localparam int unsigned RFQ_SID_DEF   = 4;
endpackage

// File: rtl/rfq_layout.sv
`timescale 1ns/1ps
// Computes every bucket's base from the committed sizes and checks a candidate size write.
module rfq_layout #(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned NBKT  = 8,
    parameter int unsigned AW    = 8,
    parameter int unsigned SZ_W  = 9,
    parameter int unsigned BW    = 3
)(
    input  logic [SZ_W-1:0] size_q [NBKT],
    input  logic [BW-1:0]   cfg_bkt,
    input  logic [SZ_W-1:0] cfg_size,
    output logic [AW-1:0]   base [NBKT],
    output logic            cand_ok
);
    localparam int unsigned TW = SZ_W + BW + 1;
    localparam logic [TW-1:0] LIM = TW'(DEPTH);

    logic [TW-1:0] acc;
    logic [TW-1:0] cacc;
    logic [TW-1:0] sx;

    always_comb begin
        acc = '0;
        for (int i = 0; i < int'(NBKT); i++) begin
            base[i] = acc[AW-1:0];
            acc     = acc + TW'(size_q[i]);
        end
    end

    always_comb begin
        cacc    = '0;
        sx      = '0;
        cand_ok = 1'b1;
        for (int i = 0; i < int'(NBKT); i++) begin
            sx = (BW'(i) == cfg_bkt) ? TW'(cfg_size) : TW'(size_q[i]);
            if (sx > LIM)
                cand_ok = 1'b0;
            if ((sx & (sx - 1'b1)) != '0)
                cand_ok = 1'b0;
            if ((sx != '0) && ((cacc & (sx - 1'b1)) != '0))
                cand_ok = 1'b0;
            cacc = cacc + sx;
        end
        if (cacc > LIM)
            cand_ok = 1'b0;
    end
endmodule

// File: rtl/rfq_bucket_ctl.sv
`timescale 1ns/1ps
// Per-bucket read offset, write offset and occupancy, wrapped by the bucket size.
module rfq_bucket_ctl #(
    parameter int unsigned AW   = 8,
    parameter int unsigned SZ_W = 9
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            push,
    input  logic            pop,
    input  logic [SZ_W-1:0] size,
    output logic [AW-1:0]   head,
    output logic [AW-1:0]   tail,
    output logic [SZ_W-1:0] count
);
    logic [SZ_W-1:0] size_m1;
    logic [AW-1:0]   mask;

    assign size_m1 = size - 1'b1;
    assign mask    = size_m1[AW-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push)
                tail <= (tail + 1'b1) & mask;
            if (pop)
                head <= (head + 1'b1) & mask;
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rfq_store.sv
`timescale 1ns/1ps
// Shared entry array: one write port and one registered read port.
module rfq_store #(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned AW    = 8,
    parameter int unsigned W     = 20
)(
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        if (re)
            rdata <= mem[raddr];
    end
endmodule

// File: rtl/rfq_rx_station.sv
`timescale 1ns/1ps
module rfq_rx_station
    import rfq_pkg::*;
#(
    parameter int unsigned DEPTH  = RFQ_DEPTH_DEF,
    parameter int unsigned NBKT   = RFQ_NBKT_DEF,
    parameter int unsigned DATA_W = RFQ_DATA_DEF,
    parameter int unsigned SID_W  = RFQ_SID_DEF
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [$clog2(NBKT)-1:0]   cfg_bkt,
    input  logic [$clog2(DEPTH):0]    cfg_size,
    output logic                      cfg_err,
    input  logic                      enq_vld,
    input  logic [$clog2(NBKT)-1:0]   enq_bkt,
    input  logic [SID_W-1:0]          enq_sid,
    input  logic [DATA_W-1:0]         enq_data,
    input  logic                      deq_req,
    input  logic [$clog2(NBKT)-1:0]   deq_bkt,
    output logic                      deq_vld,
    output logic [DATA_W-1:0]         deq_data,
    output logic [SID_W-1:0]          deq_sid,
    output logic                      cr_vld,
    output logic [$clog2(NBKT)-1:0]   cr_bkt,
    output logic [SID_W-1:0]          cr_sid,
    output logic                      err_unused,
    output logic                      err_ovf,
    output logic [NBKT-1:0]           bkt_empty
);
    localparam int unsigned AW   = $clog2(DEPTH);
    localparam int unsigned SZ_W = AW + 1;
    localparam int unsigned BW   = $clog2(NBKT);
    localparam int unsigned EW   = SID_W + DATA_W;

    logic [SZ_W-1:0] size_q [NBKT];
    logic [AW-1:0]   base   [NBKT];
    logic [AW-1:0]   head   [NBKT];
    logic [AW-1:0]   tail   [NBKT];
    logic [SZ_W-1:0] cnt    [NBKT];
    logic            cand_ok;
    logic            cfg_take, cfg_bad;
    logic            enq_none, enq_full, enq_ok, deq_ok;
    logic [AW-1:0]   wr_addr, rd_addr;
    logic [EW-1:0]   rd_entry;
    logic            pop_q, unused_q, ovf_q, cfg_err_q;
    logic [BW-1:0]   cr_bkt_q;

    rfq_layout #(.DEPTH(DEPTH), .NBKT(NBKT), .AW(AW), .SZ_W(SZ_W), .BW(BW)) u_layout (
        .size_q  (size_q),
        .cfg_bkt (cfg_bkt),
        .cfg_size(cfg_size),
        .base    (base),
        .cand_ok (cand_ok)
    );

    always_comb begin
        cfg_take = cfg_we && cand_ok;
        cfg_bad  = cfg_we && !cand_ok;
        enq_none = enq_vld && (size_q[enq_bkt] == '0);
        enq_full = enq_vld && !enq_none && (cnt[enq_bkt] == size_q[enq_bkt]);
        enq_ok   = enq_vld && !enq_none && !enq_full;
        deq_ok   = deq_req && (cnt[deq_bkt] != '0);
        wr_addr  = base[enq_bkt] + tail[enq_bkt];
        rd_addr  = base[deq_bkt] + head[deq_bkt];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NBKT); i++)
                size_q[i] <= '0;
        end else if (cfg_take) begin
            size_q[cfg_bkt] <= cfg_size;
        end
    end

    for (genvar g = 0; g < int'(NBKT); g++) begin : g_bkt
        rfq_bucket_ctl #(.AW(AW), .SZ_W(SZ_W)) u_ctl (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (cfg_take && (cfg_bkt == BW'(g))),
            .push (enq_ok && (enq_bkt == BW'(g))),
            .pop  (deq_ok && (deq_bkt == BW'(g))),
            .size (size_q[g]),
            .head (head[g]),
            .tail (tail[g]),
            .count(cnt[g])
        );
        assign bkt_empty[g] = (cnt[g] == '0);
    end

    rfq_store #(.DEPTH(DEPTH), .AW(AW), .W(EW)) u_store (
        .clk  (clk),
        .we   (enq_ok),
        .waddr(wr_addr),
        .wdata({enq_sid, enq_data}),
        .re   (deq_ok),
        .raddr(rd_addr),
        .rdata(rd_entry)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_q     <= 1'b0;
            unused_q  <= 1'b0;
            ovf_q     <= 1'b0;
            cfg_err_q <= 1'b0;
            cr_bkt_q  <= '0;
        end else begin
            pop_q    <= deq_ok;
            unused_q <= enq_none;
            ovf_q    <= enq_full;
            if (cfg_bad)
                cfg_err_q <= 1'b1;
            if (deq_ok)
                cr_bkt_q <= deq_bkt;
        end
    end

    always_comb begin
        deq_vld    = pop_q;
        deq_data   = rd_entry[DATA_W-1:0];
        deq_sid    = rd_entry[EW-1:DATA_W];
        cr_vld     = pop_q;
        cr_bkt     = cr_bkt_q;
        cr_sid     = rd_entry[EW-1:DATA_W];
        err_unused = unused_q;
        err_ovf    = ovf_q;
        cfg_err    = cfg_err_q;
    end
endmodule

// File: rtl/rfq_rx_station_chk.sv
`timescale 1ns/1ps
module rfq_rx_station_chk #(
    parameter int unsigned NBKT  = 8,
    parameter int unsigned SID_W = 4
)(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_err,
    input logic                    deq_req,
    input logic [$clog2(NBKT)-1:0] deq_bkt,
    input logic                    deq_vld,
    input logic                    cr_vld,
    input logic [$clog2(NBKT)-1:0] cr_bkt,
    input logic                    err_unused,
    input logic                    err_ovf,
    input logic [NBKT-1:0]         bkt_empty
);
    // R3
    cfg_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R6
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_req && bkt_empty[deq_bkt]) |=> !deq_vld);

    // R6
    pop_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deq_vld |-> ($past(deq_req) && !$past(bkt_empty[deq_bkt])));

    // R7
    credit_bkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cr_vld |-> (cr_bkt == $past(deq_bkt)));

    // R4
    err_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_unused |-> !err_ovf);
endmodule

bind rfq_rx_station rfq_rx_station_chk #(.NBKT(NBKT), .SID_W(SID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_err   (cfg_err),
    .deq_req   (deq_req),
    .deq_bkt   (deq_bkt),
    .deq_vld   (deq_vld),
    .cr_vld    (cr_vld),
    .cr_bkt    (cr_bkt),
    .err_unused(err_unused),
    .err_ovf   (err_ovf),
    .bkt_empty (bkt_empty)
);

// File: tb/test_rfq_rx_station.sv
`timescale 1ns/1ps
module test_rfq_rx_station;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_bkt = '0;
    logic [8:0]  cfg_size = '0;
    logic        cfg_err;
    logic        enq_vld = 1'b0;
    logic [2:0]  enq_bkt = '0;
    logic [3:0]  enq_sid = '0;
    logic [15:0] enq_data = '0;
    logic        deq_req = 1'b0;
    logic [2:0]  deq_bkt = '0;
    logic        deq_vld;
    logic [15:0] deq_data;
    logic [3:0]  deq_sid;
    logic        cr_vld;
    logic [2:0]  cr_bkt;
    logic [3:0]  cr_sid;
    logic        err_unused;
    logic        err_ovf;
    logic [7:0]  bkt_empty;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    rfq_rx_station i_rfq_rx_station (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_bkt(cfg_bkt), .cfg_size(cfg_size), .cfg_err(cfg_err),
        .enq_vld(enq_vld), .enq_bkt(enq_bkt), .enq_sid(enq_sid), .enq_data(enq_data),
        .deq_req(deq_req), .deq_bkt(deq_bkt),
        .deq_vld(deq_vld), .deq_data(deq_data), .deq_sid(deq_sid),
        .cr_vld(cr_vld), .cr_bkt(cr_bkt), .cr_sid(cr_sid),
        .err_unused(err_unused), .err_ovf(err_ovf), .bkt_empty(bkt_empty)
    );

    always #2.5 clk = ~clk;

    // op: 1 size write, 2 enqueue, 3 pop; kind: 0 quiet, 1 pop result, 2 unused error, 3 config error
    localparam logic [27:0] VEC [14] = '{
        {2'd1, 3'd0, 16'd4,     4'd0, 3'd0},
        {2'd1, 3'd1, 16'd4,     4'd0, 3'd0},
        {2'd1, 3'd2, 16'd8,     4'd0, 3'd0},
        {2'd2, 3'd0, 16'hA001,  4'd1, 3'd0},
        {2'd2, 3'd1, 16'hB001,  4'd2, 3'd0},
        {2'd2, 3'd0, 16'hA002,  4'd3, 3'd0},
        {2'd3, 3'd1, 16'hB001,  4'd2, 3'd1},
        {2'd3, 3'd0, 16'hA001,  4'd1, 3'd1},
        {2'd3, 3'd0, 16'hA002,  4'd3, 3'd1},
        {2'd3, 3'd0, 16'h0000,  4'd0, 3'd0},
        {2'd2, 3'd5, 16'hDEAD,  4'd4, 3'd2},
        {2'd1, 3'd3, 16'd3,     4'd0, 3'd3},
        {2'd2, 3'd2, 16'hC001,  4'd5, 3'd0},
        {2'd3, 3'd2, 16'hC001,  4'd5, 3'd1}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cfg_we  = 1'b0;
        enq_vld = 1'b0;
        deq_req = 1'b0;
    endtask

    task automatic do_cfg(input logic [2:0] b, input logic [8:0] s);
        cfg_we = 1'b1; cfg_bkt = b; cfg_size = s;
        tick();
    endtask

    task automatic do_enq(input logic [2:0] b, input logic [3:0] sid, input logic [15:0] d);
        enq_vld = 1'b1; enq_bkt = b; enq_sid = sid; enq_data = d;
        tick();
    endtask

    task automatic do_deq(input logic [2:0] b);
        deq_req = 1'b1; deq_bkt = b;
        tick();
    endtask

    task automatic expect_pop(input string tag, input logic [2:0] b, input logic [3:0] sid, input logic [15:0] d);
        check(deq_vld && deq_data == d && deq_sid == sid, {tag, " R6 pop data"},
              {11'd0, deq_vld, deq_sid, deq_data}, {12'd1, sid, d});
        check(cr_vld && cr_sid == sid && cr_bkt == b, {tag, " R7 credit"},
              {24'd0, cr_vld, cr_bkt, cr_sid}, {24'd1, b, sid});
    endtask

    task automatic expect_quiet(input string tag);
        check(!deq_vld && !cr_vld && !err_unused && !err_ovf, {tag, " quiet outputs"},
              {28'd0, deq_vld, cr_vld, err_unused, err_ovf}, 32'd0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1 act=running exp=finished");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        check(bkt_empty == 8'hFF, "R1 empty flags", {24'd0, bkt_empty}, 32'hFF);
        check(!cfg_err, "R1 cfg_err", {31'd0, cfg_err}, 32'd0);
        expect_quiet("R1");

        // table walk: R2 R3 R4 R6 R7
        for (int k = 0; k < 14; k++) begin
            logic [1:0]  op;
            logic [2:0]  b;
            logic [15:0] v;
            logic [3:0]  s;
            logic [2:0]  kind;
            {op, b, v, s, kind} = VEC[k];
            case (op)
                2'd1:    do_cfg(b, v[8:0]);
                2'd2:    do_enq(b, s, v);
                default: do_deq(b);
            endcase
            case (kind)
                3'd1: expect_pop("R2 table", b, s, v);
                3'd2: check(err_unused && !err_ovf, "R4 table unused bucket",
                            {30'd0, err_unused, err_ovf}, 32'd2);
                3'd3: check(cfg_err, "R3 table size not power of two", {31'd0, cfg_err}, 32'd1);
                default: begin
                    expect_quiet("R6 table");
                    if (op == 2'd1)
                        check(!cfg_err, "R3 table legal size", {31'd0, cfg_err}, 32'd0);
                end
            endcase
        end

        // R5 and R8: fill bucket 0 (size 4), overflow, then wrap
        for (int i = 0; i < 4; i++)
            do_enq(3'd0, 4'(i + 1), 16'(16'h10 + i));
        check(!bkt_empty[0], "R10 nonempty after enqueue", {31'd0, bkt_empty[0]}, 32'd0);
        do_enq(3'd0, 4'd9, 16'h99);
        check(err_ovf && !err_unused, "R5 overflow pulse", {30'd0, err_ovf, err_unused}, 32'd2);
        do_deq(3'd0);
        expect_pop("R5", 3'd0, 4'd1, 16'h10);
        check(!err_ovf, "R5 overflow pulse ends", {31'd0, err_ovf}, 32'd0);
        do_deq(3'd0);
        expect_pop("R8", 3'd0, 4'd2, 16'h11);
        do_enq(3'd0, 4'd5, 16'h14);
        do_enq(3'd0, 4'd6, 16'h15);
        do_deq(3'd0); expect_pop("R8 wrap", 3'd0, 4'd3, 16'h12);
        do_deq(3'd0); expect_pop("R8 wrap", 3'd0, 4'd4, 16'h13);
        do_deq(3'd0); expect_pop("R8 wrap", 3'd0, 4'd5, 16'h14);
        do_deq(3'd0); expect_pop("R8 wrap", 3'd0, 4'd6, 16'h15);
        check(bkt_empty[0], "R10 empty after drain", {31'd0, bkt_empty[0]}, 32'd1);

        // R9 enqueue and pop together on one bucket
        do_enq(3'd1, 4'd6, 16'h20);
        enq_vld = 1'b1; enq_bkt = 3'd1; enq_sid = 4'd7; enq_data = 16'h21;
        deq_req = 1'b1; deq_bkt = 3'd1;
        tick();
        expect_pop("R9 nonempty", 3'd1, 4'd6, 16'h20);
        check(!bkt_empty[1], "R9 occupancy kept", {31'd0, bkt_empty[1]}, 32'd0);
        do_deq(3'd1); expect_pop("R9", 3'd1, 4'd7, 16'h21);
        check(bkt_empty[1], "R9 drained", {31'd0, bkt_empty[1]}, 32'd1);
        enq_vld = 1'b1; enq_bkt = 3'd1; enq_sid = 4'd8; enq_data = 16'h22;
        deq_req = 1'b1; deq_bkt = 3'd1;
        tick();
        check(!deq_vld && !cr_vld, "R9 pop of empty ignored", {30'd0, deq_vld, cr_vld}, 32'd0);
        check(!bkt_empty[1], "R9 enqueue kept", {31'd0, bkt_empty[1]}, 32'd0);
        do_deq(3'd1); expect_pop("R9", 3'd1, 4'd8, 16'h22);

        // R3 alignment failure and R11 clear on a fresh reset
        do_reset();
        check(!cfg_err, "R1 cfg_err cleared", {31'd0, cfg_err}, 32'd0);
        do_cfg(3'd0, 9'd4);
        do_cfg(3'd1, 9'd8);
        check(cfg_err, "R3 misaligned size rejected", {31'd0, cfg_err}, 32'd1);
        do_enq(3'd1, 4'd2, 16'h30);
        check(err_unused, "R3 rejected size left bucket unused", {31'd0, err_unused}, 32'd1);
        do_cfg(3'd1, 9'd4);
        do_enq(3'd1, 4'd2, 16'h31);
        do_enq(3'd0, 4'd3, 16'h40);
        do_deq(3'd1); expect_pop("R2 second slice", 3'd1, 4'd2, 16'h31);
        do_cfg(3'd0, 9'd4);
        check(bkt_empty[0], "R11 size write empties bucket", {31'd0, bkt_empty[0]}, 32'd1);
        do_deq(3'd0);
        expect_quiet("R11 pop after clear");

        finish_run();
    end
endmodule